// File: doc/BRIEF.md
# Cascadable Reload Timer Bank

A bank of four 16-bit up-counters behind a small 16-bit register bus. Each timer owns two registers: a counter/reload register and a control register. A read of the counter register returns the live count. A write to it goes only to a hidden reload latch. The count takes the latch value when the timer overflows past 0xFFFF, and when its enable bit goes from 0 to 1.

Each timer advances on a prescaled system clock (divide by 1, 64, 256 or 1024), or by cascading. A cascading timer advances once for every overflow of the timer numbered one below it, in the same cycle as that overflow. Each timer can raise a one-cycle interrupt pulse when it overflows. To pause a cascaded timer without reloading it, disable its lower neighbour.

The bus is a plain register port: one access per cycle, writes taking effect at the clock edge, and reads combinational on the address. It has no data stream, so there is no valid/ready handshake and no back-pressure. The address is a halfword index: halfword 2i is timer i's counter/reload register, and halfword 2i+1 is its control register (byte offsets 4i and 4i+2).

Top module: `tmr_bank`

## Requirements
- R1: After reset every count, reload latch and control register reads 0 and every interrupt output is low.
- R2: A read of halfword 2i returns timer i's live count. A write there changes only the reload latch, not the count.
- R3: At the edge where control bit 7 (enable) is written from 0 to 1, the count takes the reload value and the prescaler restarts.
- R4: A tick while the count is 0xFFFF loads the reload value instead of wrapping to 0.
- R5: Control bits 2:0 select the tick source: 0 every cycle, 1 every 64 cycles, 2 every 256 cycles, 3 every 1024 cycles. The first tick comes one full period after the enable edge.
- R6: Source code 4 ticks timer i once per overflow of timer i-1, in the same cycle as that overflow. On timer 0, code 4 never ticks.
- R7: When control bit 6 is set, an overflow drives that timer's interrupt output high for the next cycle. When bit 6 is clear, the output stays low.
- R8: A disabled timer holds its count. A cascaded timer whose lower neighbour is disabled holds its count and is not reloaded when the neighbour is re-enabled.
- R9: Control bits 15:8 and 5:3 read back as 0 and ignore writes. Source codes 5 to 7 produce no ticks.
- R10: The registers of timer i sit at halfwords 2i (counter) and 2i+1 (control). An access to one timer does not touch the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | $clog2(N_TMR)+1 | Halfword register index |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| irq | output | N_TMR | Per-timer overflow interrupt pulse |

## Verification
The assertions assume at most one register access per cycle. They also assume that a write is seen by the block only in the cycle its strobe is high, so a count may change only through a tick, an overflow reload or an enable edge. The stimulus keeps to this: it drives each write on its own, between falling edges, and holds the strobe low otherwise. The stimulus also disables every timer between scenarios. This keeps stray cascade chains or half-counted prescalers from carrying over, so each expected count follows from the reload value and the number of enabled cycles alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned SH_DIV64 = 6;
  localparam int unsigned SH_DIV256 = 8;
  localparam int unsigned SH_DIV1K = 10;
  localparam int unsigned PRE_W    = SH_DIV1K;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned IE_BIT   = 6;
  localparam logic [DATA_W-1:0] CTRL_MASK = 16'h00C7;

  typedef enum logic [2:0] {
    SRC_DIV1   = 3'd0,
    SRC_DIV64  = 3'd1,
    SRC_DIV256 = 3'd2,
    SRC_DIV1K  = 3'd3,
    SRC_CASC   = 3'd4
  } tick_src_e;

  function automatic logic [PRE_W-1:0] presc_mask(input logic [2:0] code);
    case (code)
      SRC_DIV64:  presc_mask = PRE_W'((1 << SH_DIV64) - 1);
      SRC_DIV256: presc_mask = PRE_W'((1 << SH_DIV256) - 1);
      SRC_DIV1K:  presc_mask = PRE_W'((1 << SH_DIV1K) - 1);
      default:    presc_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] src,
  output logic       tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  assign mask = presc_mask(src);
  assign tick = run && (src < 3'd4) && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (run)     div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_reload,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              casc_in,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  reload,
  output logic [DATA_W-1:0] ctrl,
  output logic              en,
  output logic              ie,
  output logic [2:0]        src,
  output logic              tick,
  output logic              ovf,
  output logic              irq
);
  logic rise;
  logic presc_tick;
  logic casc_tick;

  assign en   = ctrl[EN_BIT];
  assign ie   = ctrl[IE_BIT];
  assign src  = ctrl[2:0];
  assign rise = wr_ctrl && wdata[EN_BIT] && !en;

  tmr_presc u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .restart (rise),
    .src     (src),
    .tick    (presc_tick)
  );

  assign casc_tick = en && (src == SRC_CASC) && casc_in;
  assign tick      = presc_tick || casc_tick;
  assign ovf       = tick && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
      ctrl   <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_reload) reload <= wdata[CNT_W-1:0];
      if (wr_ctrl)   ctrl   <= wdata & CTRL_MASK;
      if (rise || ovf) count <= reload;
      else if (tick)   count <= count + 1'b1;
      irq <= ovf && ie;
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned N_TMR = 4,
  localparam int unsigned AW   = $clog2(N_TMR) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_TMR-1:0]  irq
);
  localparam int unsigned CNT_W = DATA_W;

  logic [N_TMR-1:0][CNT_W-1:0]  cnt_v;
  logic [N_TMR-1:0][CNT_W-1:0]  rld_v;
  logic [N_TMR-1:0][DATA_W-1:0] ctl_v;
  logic [N_TMR-1:0][2:0]        src_v;
  logic [N_TMR-1:0] en_v, ie_v, tick_v, ovf_v, wc_v, wr_v;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic hit;
    logic casc;
    assign hit     = (bus_addr[AW-1:1] == (AW-1)'(i));
    assign wr_v[i] = bus_we && hit && !bus_addr[0];
    assign wc_v[i] = bus_we && hit && bus_addr[0];
    if (i == 0) begin : g_first
      assign casc = 1'b0;
    end else begin : g_chain
      assign casc = ovf_v[i-1];
    end
    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_reload (wr_v[i]),
      .wr_ctrl   (wc_v[i]),
      .wdata     (bus_wdata),
      .casc_in   (casc),
      .count     (cnt_v[i]),
      .reload    (rld_v[i]),
      .ctrl      (ctl_v[i]),
      .en        (en_v[i]),
      .ie        (ie_v[i]),
      .src       (src_v[i]),
      .tick      (tick_v[i]),
      .ovf       (ovf_v[i]),
      .irq       (irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (bus_addr[AW-1:1] == (AW-1)'(i))
        bus_rdata = bus_addr[0] ? ctl_v[i] : cnt_v[i];
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_pkg::*;
#(
  parameter int unsigned N_TMR = 4,
  parameter int unsigned AW    = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [AW-1:0]              bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [N_TMR-1:0]           irq,
  input logic [N_TMR-1:0][DATA_W-1:0] cnt_v,
  input logic [N_TMR-1:0][DATA_W-1:0] rld_v,
  input logic [N_TMR-1:0][2:0]      src_v,
  input logic [N_TMR-1:0]           en_v,
  input logic [N_TMR-1:0]           ie_v,
  input logic [N_TMR-1:0]           tick_v,
  input logic [N_TMR-1:0]           ovf_v,
  input logic [N_TMR-1:0]           wc_v
);
  assert_ctrl_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[0] |-> (bus_rdata[15:8] == 8'h00) && (bus_rdata[5:3] == 3'b000));

  assert_casc_t0_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_v[0] == 3'd4) |-> !tick_v[0]);

  for (genvar i = 0; i < N_TMR; i++) begin : g_chk
    assert_enable_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wc_v[i] && bus_wdata[EN_BIT] && !en_v[i]) |=> (cnt_v[i] == $past(rld_v[i])));

    assert_ovf_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_v[i] |=> (cnt_v[i] == $past(rld_v[i])));

    assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_v[i] && !wc_v[i]) |=> $stable(cnt_v[i]));

    assert_irq_on_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_v[i] && ie_v[i]) |=> irq[i]);

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_v[i] && ie_v[i]) |=> !irq[i]);

    assert_bad_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (src_v[i] > 3'd4) |-> !tick_v[i]);

    if (i > 0) begin : g_casc
      assert_casc_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_v[i] && (src_v[i] == 3'd4)) |-> ovf_v[i-1]);

      assert_casc_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_v[i] && (src_v[i] == 3'd4) && !en_v[i-1] && !wc_v[i]) |=> $stable(cnt_v[i]));
    end
  end
endmodule

bind tmr_bank tmr_bank_chk #(.N_TMR(N_TMR), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cnt_v     (cnt_v),
  .rld_v     (rld_v),
  .src_v     (src_v),
  .en_v      (en_v),
  .ie_v      (ie_v),
  .tick_v    (tick_v),
  .ovf_v     (ovf_v),
  .wc_v      (wc_v)
);

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;
  localparam int N = 4;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [N-1:0] irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_bank #(.N_TMR(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [15:0] exp_count(input logic [15:0] rl, input int ticks);
    int period;
    period = 32'h10000 - int'(rl);
    return 16'(int'(rl) + (ticks % period));
  endfunction

  function automatic int shift_of(input int code);
    case (code)
      1: return 6;
      2: return 8;
      3: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic [AW-1:0] cnt_a(input int i); return AW'(2 * i); endfunction
  function automatic logic [AW-1:0] ctl_a(input int i); return AW'(2 * i + 1); endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic all_off();
    for (int i = 0; i < N; i++) wr(ctl_a(i), 16'h0000);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20250611));
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    for (int i = 0; i < 2 * N; i++) chk_rd("R1", AW'(i), 16'h0000);
    chk("R1", 16'(irq), 16'h0000);

    // R2/R10: reload write leaves count alone, targets one timer
    wr(cnt_a(2), 16'hABCD);
    chk_rd("R2", cnt_a(2), 16'h0000);
    chk_rd("R10", ctl_a(2), 16'h0000);
    wr(ctl_a(2), 16'h0080);
    chk_rd("R3", cnt_a(2), 16'hABCD);
    chk_rd("R10", cnt_a(1), 16'h0000);
    step(10);
    chk_rd("R5", cnt_a(2), 16'hABCD + 16'd10);
    wr(cnt_a(2), 16'h1111);
    chk_rd("R2", cnt_a(2), 16'hABCD + 16'd11);
    wr(ctl_a(2), 16'h0000);
    step(20);
    chk_rd("R8", cnt_a(2), 16'hABCD + 16'd12);

    // R5: divide by 64, first tick one full period after enable
    wr(cnt_a(1), 16'h0100);
    wr(ctl_a(1), 16'h0081);
    step(63);
    chk_rd("R5", cnt_a(1), 16'h0100);
    step(1);
    chk_rd("R5", cnt_a(1), 16'h0101);
    wr(ctl_a(1), 16'h0000);

    // R4/R7: overflow reload with interrupt
    wr(cnt_a(3), 16'hFFF0);
    wr(ctl_a(3), 16'h00C0);
    step(15);
    chk_rd("R4", cnt_a(3), 16'hFFFF);
    chk("R7", 16'(irq[3]), 16'h0000);
    step(1);
    chk_rd("R4", cnt_a(3), 16'hFFF0);
    chk("R7", 16'(irq[3]), 16'h0001);
    step(1);
    chk("R7", 16'(irq[3]), 16'h0000);
    wr(ctl_a(3), 16'h0000);

    // R7: interrupt enable clear keeps the output low
    wr(cnt_a(3), 16'hFFFE);
    wr(ctl_a(3), 16'h0080);
    for (int k = 0; k < 6; k++) begin
      step(1);
      chk("R7", 16'(irq[3]), 16'h0000);
    end
    chk_rd("R4", cnt_a(3), exp_count(16'hFFFE, 6));
    wr(ctl_a(3), 16'h0000);

    // R6/R8: cascade and pause through the lower neighbour
    wr(cnt_a(0), 16'hFFFE);
    wr(cnt_a(1), 16'h0010);
    wr(ctl_a(1), 16'h0084);
    wr(ctl_a(0), 16'h0080);
    chk_rd("R6", cnt_a(1), 16'h0010);
    step(9);
    chk_rd("R6", cnt_a(1), 16'h0014);
    wr(ctl_a(0), 16'h0000);
    chk_rd("R6", cnt_a(1), 16'h0015);
    step(20);
    chk_rd("R8", cnt_a(1), 16'h0015);
    wr(ctl_a(0), 16'h0080);
    chk_rd("R8", cnt_a(1), 16'h0015);
    step(3);
    chk_rd("R6", cnt_a(1), 16'h0016);
    all_off();

    // R6/R9: timer 0 cascade and reserved bits
    wr(cnt_a(0), 16'h1234);
    wr(ctl_a(0), 16'h0084);
    step(100);
    chk_rd("R6", cnt_a(0), 16'h1234);
    wr(ctl_a(0), 16'hFFFF);
    chk_rd("R9", ctl_a(0), 16'h00C7);
    step(50);
    chk_rd("R9", cnt_a(0), 16'h1234);
    all_off();

    // Random scenarios: R5 source codes, R4 wrap, R8 hold
    for (int it = 0; it < 14; it++) begin
      int t, code, k, ticks;
      logic [15:0] rl;
      t = int'($urandom % N);
      code = int'($urandom % 4);
      k = int'($urandom % 3000);
      rl = 16'hF000 | 16'($urandom & 32'h0FFF);
      if (it == 0) rl = 16'hFFFF;
      wr(cnt_a(t), rl);
      wr(ctl_a(t), 16'h0080 | 16'(code) | (16'($urandom & 1) << 6));
      step(k);
      ticks = k >> shift_of(code);
      chk_rd("R5", cnt_a(t), exp_count(rl, ticks));
      wr(ctl_a(t), 16'h0000);
      ticks = (k + 1) >> shift_of(code);
      step(int'($urandom % 40));
      chk_rd("R8", cnt_a(t), exp_count(rl, ticks));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule